// File: doc/BRIEF.md
# Self-Rewriting Masking Look-Up Table

This block is an m-input look-up table whose truth table is held in registers, with m set by a parameter (at least three, five by default). The top input, index M-1, is a spare input fed from a reserved copy of a signal. In the normal configuration the stored function ignores the spare input, so each entry pair that differs only in that bit holds the same value. A table in which some other input is the redundant one is equally legal to load, so the unused input need not be fixed in advance.

When a line feeding an input is found to be faulty or tampered with, a reprogram command names that input. A small engine walks the whole table and builds a new one in which the spare input takes over the named input's role. The retired input then has no effect on the output, which masks any value forced onto it. The new table is assembled in a shadow copy and swapped in on a single edge. Until that edge, lookups keep using the old function.

The engine is a three-state machine. ST_IDLE accepts loads and commands. An accepted command moves to ST_WALK. ST_WALK writes one shadow entry per cycle and moves to ST_COMMIT after the last address. ST_COMMIT copies the shadow into the live table and returns to ST_IDLE.

Top module: `rectifying_lut`

## Requirements
- R1: `lut_out` equals bit n of the live truth table when `lut_in` holds the value n (input 0 is the least significant address bit).
- R2: With `busy` low, asserting `cfg_we` loads `cfg_table` into the live table at that clock edge, so it is visible from the next cycle.
- R3: An accepted reprogram naming input i replaces the table f with g, where g at address u is f at u with bit i replaced by bit M-1.
- R4: After an accepted reprogram completes, `lut_out` is identical for any two `lut_in` values that differ only in bit i.
- R5: After an accepted request, `busy` is high for exactly 2^M+1 cycles, starting the cycle after the request. During that time `lut_out` follows the old table.
- R6: `done` is high for exactly one cycle: the first cycle in which the new table drives `lut_out`, with `busy` already low.
- R7: A request made while idle whose index equals M-1 or is M or larger is rejected. `err` is high from the next cycle, `busy` stays low and the table is unchanged.
- R8: `err` stays high until the next accepted request, which clears it in the following cycle.
- R9: While `busy` is high, `cfg_we` and `rp_req` have no effect on the table or on the command in progress.
- R10: Synchronous active-high reset clears the table to all zeros and drives `busy`, `done` and `err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lut_in | input | M | LUT data inputs; bit M-1 is the spare input |
| lut_out | output | 1 | LUT output |
| cfg_we | input | 1 | Parallel table load strobe |
| cfg_table | input | 2^M | Table contents to load, entry n in bit n |
| rp_req | input | 1 | Reprogram command strobe |
| rp_idx | input | clog2(M)+1 | Index of the input to retire |
| busy | output | 1 | Rewrite in progress |
| done | output | 1 | One-cycle pulse when the new table takes effect |
| err | output | 1 | Last command was rejected |

## Verification
A wrong shadow entry or a wrong source-address bit stays hidden until the commit edge. At that edge it shows at once as a wrong `lut_out` for one address, or as a dependence on the retired input. A full sweep of all 2^M input values right after `done` therefore exposes it. A miscounted walk shows as a `busy` window of the wrong length or as an early `done`. A table that changes during the walk shows as a mismatch against the old function while `busy` is high. A rejected command that slips through shows in the next cycle as `busy` going high or `err` staying low.

// File: rtl/rlut_pkg.sv
package rlut_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WALK   = 2'd1,
        ST_COMMIT = 2'd2
    } rlut_state_e;
endpackage

// File: rtl/rlut_table.sv
module rlut_table #(
    parameter int M = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [2**M-1:0]  load_data,
    input  logic             shadow_we,
    input  logic [M-1:0]     wr_addr,
    input  logic [M-1:0]     src_addr,
    input  logic             commit,
    output logic [2**M-1:0]  active
);
    localparam int DEPTH = 2**M;

    logic [DEPTH-1:0] active_q;
    logic [DEPTH-1:0] shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '0;
        end else if (commit) begin
            active_q <= shadow_q;
        end else if (load_en) begin
            active_q <= load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (shadow_we) begin
            shadow_q[wr_addr] <= active_q[src_addr];
        end
    end

    assign active = active_q;

    // R9
    table_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!commit && !load_en) |=> $stable(active_q));
endmodule

// File: rtl/rlut_walker.sv
module rlut_walker
    import rlut_pkg::*;
#(
    parameter int M  = 5,
    parameter int IW = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rp_req,
    input  logic [IW-1:0]        rp_idx,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    output logic                 shadow_we,
    output logic                 commit,
    output logic [M-1:0]         walk_addr,
    output logic [M-1:0]         src_addr,
    output logic [$clog2(M)-1:0] retire_idx
);
    localparam int SW = $clog2(M);
    localparam logic [IW-1:0] SPARE_I = IW'(M - 1);
    localparam logic [M-1:0]  LAST_A  = '1;

    rlut_state_e state_q, state_d;
    logic [M-1:0]  addr_q;
    logic [SW-1:0] idx_q;
    logic          err_q, done_q;
    logic          accept, reject;

    assign accept = rp_req && (state_q == ST_IDLE) && (rp_idx < SPARE_I);
    assign reject = rp_req && (state_q == ST_IDLE) && (rp_idx >= SPARE_I);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_WALK;
            ST_WALK:   if (addr_q == LAST_A) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = 1'b1;
        shadow_we = 1'b0;
        commit    = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_WALK:   shadow_we = 1'b1;
            ST_COMMIT: commit = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            idx_q  <= '0;
            err_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_COMMIT);
            if (accept) begin
                idx_q  <= rp_idx[SW-1:0];
                addr_q <= '0;
                err_q  <= 1'b0;
            end else if (reject) begin
                err_q <= 1'b1;
            end
            if (state_q == ST_WALK) addr_q <= addr_q + 1'b1;
        end
    end

    for (genvar b = 0; b < M; b++) begin : g_src
        assign src_addr[b] = (idx_q == SW'(b)) ? addr_q[M-1] : addr_q[b];
    end

    assign walk_addr  = addr_q;
    assign retire_idx = idx_q;
    assign err        = err_q;
    assign done       = done_q;

    // R5
    walk_run_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WALK && addr_q != LAST_A) |=> (state_q == ST_WALK));
endmodule

// File: rtl/rlut_lookup.sv
module rlut_lookup #(
    parameter int M = 5
) (
    input  logic [2**M-1:0] table_bits,
    input  logic [M-1:0]    sel,
    output logic            y
);
    assign y = table_bits[sel];
endmodule

// File: rtl/rectifying_lut.sv
module rectifying_lut #(
    parameter int M = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [M-1:0]         lut_in,
    output logic                 lut_out,
    input  logic                 cfg_we,
    input  logic [2**M-1:0]      cfg_table,
    input  logic                 rp_req,
    input  logic [$clog2(M):0]   rp_idx,
    output logic                 busy,
    output logic                 done,
    output logic                 err
);
    localparam int DEPTH = 2**M;
    localparam int SW    = $clog2(M);
    localparam int IW    = SW + 1;
    localparam logic [IW-1:0] SPARE_I = IW'(M - 1);

    logic [DEPTH-1:0] table_q;
    logic [M-1:0]     walk_addr, src_addr;
    logic [SW-1:0]    retire_idx;
    logic             shadow_we, commit, load_en;

    assign load_en = cfg_we && !busy;

    rlut_walker #(.M(M), .IW(IW)) u_walker (
        .clk        (clk),
        .rst        (rst),
        .rp_req     (rp_req),
        .rp_idx     (rp_idx),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .shadow_we  (shadow_we),
        .commit     (commit),
        .walk_addr  (walk_addr),
        .src_addr   (src_addr),
        .retire_idx (retire_idx)
    );

    rlut_table #(.M(M)) u_table (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_data (cfg_table),
        .shadow_we (shadow_we),
        .wr_addr   (walk_addr),
        .src_addr  (src_addr),
        .commit    (commit),
        .active    (table_q)
    );

    rlut_lookup #(.M(M)) u_lookup (
        .table_bits (table_q),
        .sel        (lut_in),
        .y          (lut_out)
    );

    function automatic logic input_dead(logic [DEPTH-1:0] t, logic [SW-1:0] k);
        logic ok;
        ok = 1'b1;
        for (int a = 0; a < DEPTH; a++) begin
            logic [M-1:0] av;
            logic [M-1:0] bv;
            av = M'(a);
            bv = av ^ (M'(1) << k);
            if (t[av] != t[bv]) ok = 1'b0;
        end
        return ok;
    endfunction

    // R4
    retired_dead_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> input_dead(table_q, retire_idx));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7
    reject_keeps_table_chk: assert property (@(posedge clk) disable iff (rst)
        (rp_req && !busy && rp_idx >= SPARE_I && !cfg_we) |=>
            ($stable(table_q) && err && !busy));

    // R8
    accept_clears_err_chk: assert property (@(posedge clk) disable iff (rst)
        (rp_req && !busy && rp_idx < SPARE_I) |=> (busy && !err));
endmodule

// File: tb/tb_rectifying_lut.sv
`timescale 1ns/1ps
module tb_rectifying_lut;
    localparam int M     = 5;
    localparam int DEPTH = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [M-1:0]      lut_in = '0;
    logic              lut_out;
    logic              cfg_we = 1'b0;
    logic [DEPTH-1:0]  cfg_table = '0;
    logic              rp_req = 1'b0;
    logic [3:0]        rp_idx = '0;
    logic              busy, done, err;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    rectifying_lut #(.M(M)) dut (
        .clk(clk), .rst(rst), .lut_in(lut_in), .lut_out(lut_out),
        .cfg_we(cfg_we), .cfg_table(cfg_table), .rp_req(rp_req),
        .rp_idx(rp_idx), .busy(busy), .done(done), .err(err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DEPTH-1:0] reprog(logic [DEPTH-1:0] t, int k);
        logic [DEPTH-1:0] g;
        for (int a = 0; a < DEPTH; a++) begin
            logic [M-1:0] av;
            logic [M-1:0] sv;
            av = M'(a);
            sv = av;
            sv[k] = av[M-1];
            g[a] = t[sv];
        end
        return g;
    endfunction

    function automatic logic [DEPTH-1:0] spare_free(logic [15:0] h);
        logic [DEPTH-1:0] t;
        for (int a = 0; a < DEPTH; a++) t[a] = h[a % 16];
        return t;
    endfunction

    // sweep all inputs, compare with exp, optionally check bit k is dead
    task automatic sweep(input logic [DEPTH-1:0] exp, input string req, input int dead_k);
        logic [DEPTH-1:0] seen;
        for (int a = 0; a < DEPTH; a++) begin
            lut_in = M'(a);
            #1;
            seen[a] = lut_out;
        end
        check(seen == exp, req, int'(seen), int'(exp));
        if (dead_k >= 0) begin
            bit ok = 1'b1;
            for (int a = 0; a < DEPTH; a++)
                if (seen[a] != seen[a ^ (1 << dead_k)]) ok = 1'b0;
            check(ok, "R4 retired input dead", int'(seen), int'(exp));
        end
    endtask

    task automatic load(input logic [DEPTH-1:0] t);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_table = t;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reprogram(input logic [DEPTH-1:0] old_t, input int k, input bit poke);
        logic [DEPTH-1:0] exp_t;
        int cnt;
        exp_t = reprog(old_t, k);
        @(negedge clk);
        rp_req = 1'b1;
        rp_idx = 4'(k);
        @(negedge clk);
        rp_req = 1'b0;
        check(busy == 1'b1, "R5 busy after accept", busy, 1);
        check(err == 1'b0, "R8 err cleared by accept", err, 0);
        cnt = 0;
        while (busy && cnt < 100) begin
            lut_in = M'($urandom % DEPTH);
            #1;
            check(lut_out == old_t[lut_in], "R5 old table while busy", lut_out, old_t[lut_in]);
            if (poke && cnt == 4) begin
                cfg_we = 1'b1;          // R9 must be ignored
                cfg_table = ~old_t;
                rp_req = 1'b1;
                rp_idx = 4'((k + 1) % 4);
            end else begin
                cfg_we = 1'b0;
                rp_req = 1'b0;
            end
            cnt++;
            @(negedge clk);
        end
        cfg_we = 1'b0;
        rp_req = 1'b0;
        check(cnt == DEPTH + 1, "R5 busy length", cnt, DEPTH + 1);
        check(done == 1'b1, "R6 done with new table", done, 1);
        sweep(exp_t, poke ? "R9 R3 new table" : "R3 new table", k);
        @(negedge clk);
        check(done == 1'b0, "R6 done single cycle", done, 0);
    endtask

    task automatic reject(input logic [DEPTH-1:0] cur, input int k);
        @(negedge clk);
        rp_req = 1'b1;
        rp_idx = 4'(k);
        @(negedge clk);
        rp_req = 1'b0;
        check(err == 1'b1, "R7 err on bad index", err, 1);
        check(busy == 1'b0, "R7 no busy on bad index", busy, 0);
        sweep(cur, "R7 table unchanged", -1);
        @(negedge clk);
        check(err == 1'b1, "R8 err held", err, 1);
    endtask

    initial begin
        logic [DEPTH-1:0] t;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10
        check(busy == 0 && done == 0 && err == 0, "R10 reset flags", {busy, done, err}, 0);
        sweep('0, "R10 reset table", -1);

        // R1 R2 directed
        t = 32'hA5C3_0F96;
        load(t);
        sweep(t, "R1 R2 lookup", -1);

        // R7 bad indices
        reject(t, M - 1);
        reject(t, 7);

        // R3 R4 directed, with R9 pokes
        t = spare_free(16'hB36E);
        load(t);
        sweep(t, "R2 load", -1);
        reprogram(t, 0, 1'b1);
        t = reprog(t, 0);

        // random spare-free tables
        for (int it = 0; it < 6; it++) begin
            logic [DEPTH-1:0] r;
            int k;
            r = spare_free(16'($urandom));
            k = int'($urandom % (M - 1));
            load(r);
            reprogram(r, k, it[0]);
        end

        // chained reprogram on an arbitrary table
        t = 32'($urandom);
        load(t);
        reprogram(t, 2, 1'b0);
        t = reprog(t, 2);
        reprogram(t, 3, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #4000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule